// File: doc/BRIEF.md
# Sequential ones' complement multiply/divide unit

This block performs multiplication and division on 18-bit ones' complement words, one iteration per clock. It works on a double-length register pair made of an upper half (the accumulator) and a lower half (the IO word). A multiply takes the accumulator value and an operand and returns the double-length product in the pair. A divide takes a double-length dividend from the pair and a divisor operand, and returns the quotient in the upper half and the remainder in the lower half.

A caller pulses `start_i` with the operation select and the operands. `busy_o` stays high while the operation runs. A single-cycle `done_o` pulse marks valid results, which stay held until the next operation completes. Both operations first turn the operands into magnitudes by complementing any negative word. A multiply then runs 17 add-and-shift-right steps. A divide runs 18 non-restoring steps, with a remainder correction at the end. Signs are restored afterwards by ones' complement rules. A divide whose quotient would not fit is refused: it reports overflow and leaves the pair untouched. A successful divide raises a skip flag.

Top module: `md_seq_unit`

## Requirements
- R1: After reset, busy_o, done_o, ovf_o and skip_o are 0, and ac_o and io_o are 0.
- R2: Multiply (op_div_i=0). Let |x| be x when x[17]=0 and ~x when x[17]=1. The 36-bit value {ac_o,io_o} equals 2*|ac_i|*|opnd_i|. That means ac_o[17]=0 and io_o[0]=0 before the sign is applied. io_i is ignored. ovf_o=0 and skip_o=0.
- R3: For a multiply, when ac_i[17] differs from opnd_i[17] and the product is non-zero, both ac_o and io_o are complemented. A zero product, including one from a negative-zero operand (all ones), is never complemented.
- R4: Divide (op_div_i=1). D is {ac_i,io_i}, with all 36 bits complemented when ac_i[17]=1. D' is D[35:1]. When D[35:18] < |opnd_i|, the magnitude of ac_o is D'/|opnd_i| and the magnitude of io_o is D' mod |opnd_i|. skip_o=1 and ovf_o=0.
- R5: For a successful divide, ac_o is complemented when ac_i[17] differs from opnd_i[17] and the quotient is non-zero. io_o is complemented when ac_i[17]=1 and the remainder is non-zero.
- R6: When a divide has D[35:18] >= |opnd_i|, which covers any divisor of +0 or -0, the divide aborts. ac_o=ac_i, io_o=io_i, ovf_o=1 and skip_o=0.
- R7: done_o is high for exactly one cycle. Count the rising edge that samples start_i as edge 1. done_o is then high after edge 19 for a multiply, after edge 20 for a divide, and after edge 2 for an aborted divide.
- R8: busy_o is high from the edge that accepts start_i until done_o rises, and busy_o is low whenever done_o is high.
- R9: A start_i pulse while busy_o is high is ignored, and the operation in flight completes with its original operands.
- R10: ac_o, io_o, ovf_o and skip_o change only in the cycle in which done_o rises, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| op_div_i | input | 1 | 1 = divide, 0 = multiply |
| ac_i | input | 18 | Upper half of the pair: multiplier or dividend high word |
| io_i | input | 18 | Lower half of the pair: dividend low word |
| opnd_i | input | 18 | Multiplicand or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ac_o | output | 18 | Product high word or quotient |
| io_o | output | 18 | Product low word or remainder |
| ovf_o | output | 1 | Divide refused (quotient would not fit) |
| skip_o | output | 1 | Divide completed successfully |

## Verification
The bench goes after several corner cases. With negative-zero operands and with zero products of mixed sign, a design that complements without testing for zero returns all ones instead of +0. Divides whose high half exactly equals the divisor, or whose divisor is +0 or -0, must abort; an off-by-one in the compare would run the divide and return a wrong quotient with skip set. Negative dividends and divisors exercise the partial-remainder correction and both sign rules, where a missing correction leaves the remainder off by one divisor. A second start issued mid-run would corrupt the result if it were accepted, and latency is counted per operation.

// File: rtl/md_pkg.sv
package md_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } md_state_e;

  localparam int unsigned MD_WORD_W = 18;

endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
  import md_pkg::*;
#(
  parameter int unsigned MUL_STEPS = 17,
  parameter int unsigned DIV_STEPS = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic is_div_i,
  input  logic abort_i,
  output logic accept_o,
  output logic step_o,
  output logic last_o,
  output logic fin_o,
  output logic div_o,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned MAX_STEPS = (DIV_STEPS > MUL_STEPS) ? DIV_STEPS : MUL_STEPS;
  localparam int unsigned CW = $clog2(MAX_STEPS + 1);
  localparam logic [CW-1:0] MUL_LAST = CW'(MUL_STEPS - 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_STEPS - 1);

  md_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          div_q, div_n;
  logic          done_q, done_n;
  logic          cnt_en, div_en;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign step_o   = (state_q == ST_RUN);
  assign fin_o    = (state_q == ST_FIN);
  assign last_o   = step_o && (cnt_q == (div_q ? DIV_LAST : MUL_LAST));
  assign div_o    = div_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    div_n   = div_q;
    done_n  = 1'b0;
    cnt_en  = 1'b0;
    div_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          state_n = (is_div_i && abort_i) ? ST_FIN : ST_RUN;
          cnt_n   = '0;
          cnt_en  = 1'b1;
          div_n   = is_div_i;
          div_en  = 1'b1;
        end
      end
      ST_RUN: begin
        cnt_n  = cnt_q + 1'b1;
        cnt_en = 1'b1;
        if (last_o) state_n = ST_FIN;
      end
      ST_FIN: begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 1'b0;
    end else if (div_en) begin
      div_q <= div_n;
    end
  end

  // R7: the step counter never runs past the longer iteration count
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (cnt_q < CW'(MAX_STEPS)));

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: completion is only ever seen with the sequencer back at rest
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));

  // R9: a start seen mid-run leaves the sequencer busy or finishing
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !last_o && start_i) |=> (state_q == ST_RUN));

endmodule

// File: rtl/md_mul_step.sv
module md_mul_step #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] io_i,
  input  logic [W-1:0] mcand_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] io_o
);

  logic [W-1:0] sum;

  // the upper half stays below half range, so the add cannot carry out
  always_comb begin
    sum  = io_i[0] ? (ac_i + mcand_i) : ac_i;
    ac_o = {1'b0, sum[W-1:1]};
    io_o = {sum[0], io_i[W-1:1]};
  end

endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] io_i,
  input  logic [W-1:0] dvsr_i,
  input  logic         neg_i,
  input  logic         last_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] io_o,
  output logic         neg_o
);

  logic [W-1:0] part;

  always_comb begin
    part  = neg_i ? (ac_i + dvsr_i) : (ac_i - dvsr_i);
    neg_o = part[W-1];
    ac_o  = last_i ? part : {part[W-2:0], io_i[W-1]};
    io_o  = {io_i[W-2:0], ~part[W-1]};
  end

endmodule

// File: rtl/md_result_fix.sv
module md_result_fix #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fin_i,
  input  logic         is_div_i,
  input  logic         abort_i,
  input  logic         sgn_res_i,
  input  logic         sgn_dvd_i,
  input  logic         neg_i,
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] io_i,
  input  logic [W-1:0] dvsr_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] io_o,
  output logic         ovf_o,
  output logic         skip_o
);

  logic [W-1:0] rem;
  logic         prod_nz;

  always_comb begin
    rem     = neg_i ? (ac_i + dvsr_i) : ac_i;
    prod_nz = (ac_i != '0) || (io_i != '0);
    ovf_o   = is_div_i && abort_i;
    skip_o  = is_div_i && !abort_i;
    if (!is_div_i) begin
      ac_o = (sgn_res_i && prod_nz) ? ~ac_i : ac_i;
      io_o = (sgn_res_i && prod_nz) ? ~io_i : io_i;
    end else if (abort_i) begin
      ac_o = ac_i;
      io_o = io_i;
    end else begin
      ac_o = (sgn_res_i && (io_i != '0)) ? ~io_i : io_i;
      io_o = (sgn_dvd_i && (rem != '0)) ? ~rem : rem;
    end
  end

  // R4: the corrected remainder magnitude is below the divisor magnitude
  p_rem_below_dvsr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && is_div_i && !abort_i) |-> (rem < dvsr_i));

  // R2: a product leaves the top bit of the upper half equal to the lowest bit of the lower half
  p_prod_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && !is_div_i) |-> (ac_o[W-1] == io_o[0]));

endmodule

// File: rtl/md_seq_unit.sv
module md_seq_unit
  import md_pkg::*;
#(
  parameter int unsigned W = MD_WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         op_div_i,
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] io_i,
  input  logic [W-1:0] opnd_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] io_o,
  output logic         ovf_o,
  output logic         skip_o
);

  localparam int unsigned MUL_STEPS = W - 1;
  localparam int unsigned DIV_STEPS = W;

  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta_q, rs_sync_q;
  logic rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end
  assign rst_s_n = rs_sync_q;

  // operand magnitudes and the divide range test, formed at start
  logic         a_neg, m_neg;
  logic [W-1:0] mag_ac, mag_io, mag_m;
  logic         div_abort;

  always_comb begin
    a_neg     = ac_i[W-1];
    m_neg     = opnd_i[W-1];
    mag_ac    = a_neg ? ~ac_i : ac_i;
    mag_io    = a_neg ? ~io_i : io_i;
    mag_m     = m_neg ? ~opnd_i : opnd_i;
    div_abort = (mag_ac >= mag_m);
  end

  // sequencer
  logic accept, step, last, fin, div_run;

  md_ctrl #(
    .MUL_STEPS (MUL_STEPS),
    .DIV_STEPS (DIV_STEPS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .start_i  (start_i),
    .is_div_i (op_div_i),
    .abort_i  (div_abort),
    .accept_o (accept),
    .step_o   (step),
    .last_o   (last),
    .fin_o    (fin),
    .div_o    (div_run),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  // working state
  logic [W-1:0] wac_q, wac_n;
  logic [W-1:0] wio_q, wio_n;
  logic [W-1:0] v_q;
  logic         neg_q, neg_n;
  logic         sgnr_q, sgnd_q, abort_q;
  logic         work_en;

  logic [W-1:0] mul_ac, mul_io, div_ac, div_io;
  logic         div_neg;

  md_mul_step #(.W(W)) u_mul_step (
    .ac_i    (wac_q),
    .io_i    (wio_q),
    .mcand_i (v_q),
    .ac_o    (mul_ac),
    .io_o    (mul_io)
  );

  md_div_step #(.W(W)) u_div_step (
    .ac_i   (wac_q),
    .io_i   (wio_q),
    .dvsr_i (v_q),
    .neg_i  (neg_q),
    .last_i (last),
    .ac_o   (div_ac),
    .io_o   (div_io),
    .neg_o  (div_neg)
  );

  always_comb begin
    wac_n   = wac_q;
    wio_n   = wio_q;
    neg_n   = neg_q;
    work_en = 1'b0;
    if (accept) begin
      work_en = 1'b1;
      neg_n   = 1'b0;
      if (!op_div_i) begin
        wac_n = '0;
        wio_n = mag_ac;
      end else if (div_abort) begin
        wac_n = ac_i;
        wio_n = io_i;
      end else begin
        wac_n = mag_ac;
        wio_n = mag_io;
      end
    end else if (step) begin
      work_en = 1'b1;
      if (div_run) begin
        wac_n = div_ac;
        wio_n = div_io;
        neg_n = div_neg;
      end else begin
        wac_n = mul_ac;
        wio_n = mul_io;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wac_q <= '0;
      wio_q <= '0;
      neg_q <= 1'b0;
    end else if (work_en) begin
      wac_q <= wac_n;
      wio_q <= wio_n;
      neg_q <= neg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      v_q     <= '0;
      sgnr_q  <= 1'b0;
      sgnd_q  <= 1'b0;
      abort_q <= 1'b0;
    end else if (accept) begin
      v_q     <= mag_m;
      sgnr_q  <= a_neg ^ m_neg;
      sgnd_q  <= a_neg;
      abort_q <= op_div_i && div_abort;
    end
  end

  // sign restore and result registers
  logic [W-1:0] fix_ac, fix_io;
  logic         fix_ovf, fix_skip;

  md_result_fix #(.W(W)) u_fix (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .fin_i     (fin),
    .is_div_i  (div_run),
    .abort_i   (abort_q),
    .sgn_res_i (sgnr_q),
    .sgn_dvd_i (sgnd_q),
    .neg_i     (neg_q),
    .ac_i      (wac_q),
    .io_i      (wio_q),
    .dvsr_i    (v_q),
    .ac_o      (fix_ac),
    .io_o      (fix_io),
    .ovf_o     (fix_ovf),
    .skip_o    (fix_skip)
  );

  logic [W-1:0] res_ac_q, res_io_q;
  logic         res_ovf_q, res_skip_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      res_ac_q   <= '0;
      res_io_q   <= '0;
      res_ovf_q  <= 1'b0;
      res_skip_q <= 1'b0;
    end else if (fin) begin
      res_ac_q   <= fix_ac;
      res_io_q   <= fix_io;
      res_ovf_q  <= fix_ovf;
      res_skip_q <= fix_skip;
    end
  end

  assign ac_o   = res_ac_q;
  assign io_o   = res_io_q;
  assign ovf_o  = res_ovf_q;
  assign skip_o = res_skip_q;

  // R10: results move only together with the completion pulse
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !done_o |-> ($stable(ac_o) && $stable(io_o) && $stable(ovf_o) && $stable(skip_o)));

  // R6: a refused divide completes two edges after acceptance with overflow set
  p_abort_fast_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (accept && op_div_i && div_abort) |=> ##1 (done_o && ovf_o && !skip_o));

  // R8: busy and completion never overlap
  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |-> !busy_o);

  // R9: the divisor magnitude captured at start is not reloaded mid-run
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy_o && start_i) |=> $stable(v_q));

endmodule

// File: tb/md_seq_unit_tb_top.sv
`timescale 1ns/1ps
module md_seq_unit_tb_top;

  localparam int W = 18;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         op_div_i;
  logic [W-1:0] ac_i, io_i, opnd_i;
  logic         busy_o, done_o, ovf_o, skip_o;
  logic [W-1:0] ac_o, io_o;

  int total = 0;
  int bad   = 0;

  md_seq_unit #(.W(W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_div_i (op_div_i),
    .ac_i     (ac_i),
    .io_i     (io_i),
    .opnd_i   (opnd_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .ac_o     (ac_o),
    .io_o     (io_o),
    .ovf_o    (ovf_o),
    .skip_o   (skip_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mag(input logic [W-1:0] x);
    return x[W-1] ? ~x : x;
  endfunction

  // expected {ac, io, ovf, skip}
  function automatic logic [2*W+1:0] ref_result(input bit is_div, input logic [W-1:0] a,
                                                input logic [W-1:0] lo, input logic [W-1:0] m);
    logic [2*W-1:0] p, d;
    logic [2*W-2:0] d1;
    logic [W-1:0]   mm, qa, ra;
    logic [63:0]    q, r;
    mm = mag(m);
    if (!is_div) begin
      p = (2*W)'(64'(mag(a)) * 64'(mm) * 64'd2);
      if ((a[W-1] ^ m[W-1]) && (p != '0)) p = ~p;
      return {p, 1'b0, 1'b0};
    end
    d = a[W-1] ? ~{a, lo} : {a, lo};
    if (d[2*W-1:W] >= mm) return {a, lo, 1'b1, 1'b0};
    d1 = d[2*W-1:1];
    q  = 64'(d1) / 64'(mm);
    r  = 64'(d1) % 64'(mm);
    qa = W'(q);
    ra = W'(r);
    if ((a[W-1] ^ m[W-1]) && (qa != '0)) qa = ~qa;
    if (a[W-1] && (ra != '0)) ra = ~ra;
    return {qa, ra, 1'b0, 1'b1};
  endfunction

  task automatic run_op(input bit is_div, input logic [W-1:0] a, input logic [W-1:0] lo,
                        input logic [W-1:0] m, input int inject_at, input string tag);
    logic [2*W+1:0] exp;
    int n;
    int exp_lat;
    bit busy_ok;
    string rq;
    exp = ref_result(is_div, a, lo, m);
    exp_lat = !is_div ? 19 : (exp[1] ? 2 : 20);
    rq = !is_div ? "R2/R3" : (exp[1] ? "R6" : "R4/R5");
    busy_ok = 1'b1;
    @(negedge clk);
    start_i = 1'b1; op_div_i = is_div; ac_i = a; io_i = lo; opnd_i = m;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && n < 60) begin
      if (!busy_o) busy_ok = 1'b0;
      if (n == inject_at) begin
        start_i = 1'b1; op_div_i = ~is_div; ac_i = ~a; io_i = ~lo; opnd_i = m ^ 18'h00155;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(busy_ok, "R8", {tag, " busy high while running"}, 64'(busy_ok), 64'd1);
    chk(n == exp_lat, "R7", {tag, " latency"}, 64'(n), 64'(exp_lat));
    chk(!busy_o, "R8", {tag, " busy low at done"}, 64'(busy_o), 64'd0);
    chk(ac_o == exp[2*W+1:W+2], (inject_at > 0) ? "R9" : rq, {tag, " ac_o"}, 64'(ac_o), 64'(exp[2*W+1:W+2]));
    chk(io_o == exp[W+1:2], (inject_at > 0) ? "R9" : rq, {tag, " io_o"}, 64'(io_o), 64'(exp[W+1:2]));
    chk({ovf_o, skip_o} == exp[1:0], is_div ? "R6" : "R10", {tag, " ovf/skip"},
        64'({ovf_o, skip_o}), 64'(exp[1:0]));
    @(negedge clk);
    chk(!done_o, "R7", {tag, " done one cycle"}, 64'(done_o), 64'd0);
    chk({ac_o, io_o, ovf_o, skip_o} == exp, "R10", {tag, " held after done"},
        64'({ac_o, io_o, ovf_o, skip_o}), 64'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rl, rm;
    void'($urandom(32'd7919));
    rst_n = 1'b0; start_i = 1'b0; op_div_i = 1'b0;
    ac_i = '0; io_i = '0; opnd_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!busy_o, "R1", "busy in reset", 64'(busy_o), 64'd0);
    chk(!done_o, "R1", "done in reset", 64'(done_o), 64'd0);
    chk(ac_o == '0 && io_o == '0, "R1", "results in reset", 64'({ac_o, io_o}), 64'd0);
    chk(!ovf_o && !skip_o, "R1", "flags in reset", 64'({ovf_o, skip_o}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o, "R1", "idle after release", 64'({busy_o, done_o}), 64'd0);

    // directed multiplies (R2, R3)
    run_op(1'b0, 18'd3, 18'd0, 18'd5, 0, "R2 mul 3*5");
    run_op(1'b0, ~18'd3, 18'h3ffff, 18'd5, 0, "R3 mul -3*5");
    run_op(1'b0, 18'h3ffff, 18'd0, 18'd5, 0, "R3 mul -0*5");
    run_op(1'b0, 18'd7, 18'd0, 18'h3ffff, 0, "R3 mul 7*-0");
    run_op(1'b0, 18'h1ffff, 18'd0, 18'h1ffff, 0, "R2 mul max*max");
    run_op(1'b0, 18'h20000, 18'd0, 18'h20000, 0, "R3 mul min*min");
    // directed divides (R4, R5, R6)
    run_op(1'b1, 18'd0, 18'd200, 18'd7, 0, "R4 div 100/7");
    run_op(1'b1, ~18'd0, ~18'd200, 18'd7, 0, "R5 div neg dividend");
    run_op(1'b1, 18'd1, 18'd12345, ~18'd9, 0, "R5 div neg divisor");
    run_op(1'b1, 18'd2, 18'd0, 18'd3, 0, "R4 div exact pow");
    run_op(1'b1, 18'd5, 18'd0, 18'd5, 0, "R6 div equal abort");
    run_op(1'b1, 18'd0, 18'd99, 18'd0, 0, "R6 div by +0");
    run_op(1'b1, 18'd0, 18'd99, 18'h3ffff, 0, "R6 div by -0");
    run_op(1'b1, ~18'd4, 18'd1, ~18'd5, 0, "R5 div both neg");
    // R9 starts while busy
    run_op(1'b0, 18'd1234, 18'd0, 18'd77, 5, "R9 mul restart");
    run_op(1'b1, 18'd3, 18'd555, 18'd1000, 9, "R9 div restart");
    run_op(1'b1, 18'd9, 18'd1, 18'd4, 1, "R9 abort restart");

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      ra = W'($urandom);
      rl = W'($urandom);
      rm = W'($urandom);
      if (($urandom % 4) != 0 && mag(rm) != '0) begin
        ra = W'($urandom % mag(rm));
        if ($urandom % 2) ra = ~ra;
      end
      run_op(1'(i % 2), ra, rl, rm, 0, "rand");
    end

    // R10 results hold while idle
    repeat (5) @(negedge clk);
    chk(!done_o && !busy_o, "R10", "idle after run", 64'({done_o, busy_o}), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule